// File: doc/BRIEF.md
# Steerable Supervisor Watchdog Timer

This block watches a host processor. The host arms it by writing one 8-bit configuration byte. The byte holds a 5-bit multiplier, a 2-bit resolution code and a steering bit. The timeout is the multiplier times a base resolution. The timeout is counted in ticks, where one tick is 1/16 s, so the four resolution codes give 1, 4, 16 or 64 ticks per unit. The tick enables come from a base-clock divider outside the block. Each accepted write of the byte restarts the period. A multiplier of zero leaves the watchdog idle.

When the period runs out without a write, the steering bit selects the response:
- With steering set, the block emits a reset pulse of fixed length. The pulse clears the whole configuration byte, so the watchdog ends up disabled.
- With steering clear, the block pulls its interrupt output low. The interrupt stays low until the host writes the byte again or a power failure is signalled.

Every timeout also produces a one-cycle flag pulse that a neighbouring flags register can latch. A power-fail input clears the configuration, so software must re-arm the watchdog after boot.

Top module: `wdog_supervisor`

## Requirements
- R1: After a synchronous reset, the configuration readback is 0x00, `wd_rst_n` and `wd_int_n` are high, and `wd_flag` is low.
- R2: The byte layout is bit 7 = steering, bits 6..2 = multiplier M, bits 1..0 = resolution code C. The timeout is M·4^C ticks, so codes 0, 1, 2 and 3 mean 1, 4, 16 and 64 ticks per unit. The timeout takes effect in the cycle after the clock edge that samples the M·4^C-th tick following the last accepted write.
- R3: When M = 0, no timeout ever occurs, whatever ticks arrive.
- R4: An accepted write restarts the count from zero. A tick present in the same cycle as the write is not counted. A write in the same cycle as the expiring tick counts as a service, and no timeout occurs.
- R5: Each timeout raises `wd_flag` for exactly one cycle. After a timeout, no further timeout occurs until the next accepted write.
- R6: With steering = 1, `wd_rst_n` goes low for exactly RST_CYCLES cycles, starting in the cycle after the expiring edge. The configuration reads 0x00 from that cycle on. Writes that arrive while the pulse is low are ignored.
- R7: With steering = 0, `wd_int_n` goes low at the timeout. It stays low over any number of further ticks until an accepted write or a power-fail cycle.
- R8: A cycle with `pwr_fail` high clears the configuration to 0x00, discards the count, releases `wd_int_n` and blocks any write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle enable, one per 1/16 s |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte to write |
| pwr_fail | input | 1 | Power-failure indication, active high |
| cfg_rdata | output | 8 | Current configuration byte |
| wd_rst_n | output | 1 | Reset pulse output, active low |
| wd_int_n | output | 1 | Interrupt output, active low, level |
| wd_flag | output | 1 | One-cycle pulse on every timeout |

## Verification
The assertions assume that `tick`, `cfg_wr` and `pwr_fail` are synchronous to `clk`. They also assume that `rst_n` is held low across the first clock edges, so that every register has a known value before any property is evaluated. The bench drives every input on the falling clock edge, keeps `tick` to single-cycle pulses, and holds reset low for several cycles before releasing it. Because of this, no input changes near the sampling edge. Writes during a reset pulse and writes that coincide with an expiring tick are produced on purpose, since the block must handle both.

// File: rtl/wdog_pkg.sv
// Shared field widths and the configuration byte type for the watchdog.
// Assumes an 8-bit byte: steering, multiplier and resolution code, MSB first.
package wdog_pkg;
    localparam int MULT_W = 5;
    localparam int RES_W  = 2;
    localparam int CFG_W  = 1 + MULT_W + RES_W;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wd_cfg_t;
endpackage

// File: rtl/wdog_cfg_reg.sv
// Holds the configuration byte.
// Assumes pwr_fail and clr_req are synchronous single-cycle or level requests.
// Writes are refused while a reset pulse is active or power has failed.
module wdog_cfg_reg
    import wdog_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en,
    input  wd_cfg_t wr_data,
    input  logic    pwr_fail,
    input  logic    pulse_active,
    input  logic    clr_req,
    output wd_cfg_t cfg_q,
    output logic    wr_ok
);
    // A write is accepted only outside a reset pulse and a power failure
    assign wr_ok = wr_en && !pulse_active && !pwr_fail;

    // Register update: clear on power failure or reset-steered expiry, else load
    always_ff @(posedge clk) begin
        if (!rst_n)                 cfg_q <= '0;
        else if (pwr_fail || clr_req) cfg_q <= '0;
        else if (wr_ok)             cfg_q <= wr_data;
    end

    p_pwrfail_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (cfg_q == '0));
    p_pulse_blocks_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_active && !clr_req && !pwr_fail) |=> $stable(cfg_q));
endmodule

// File: rtl/wdog_timer.sv
// Counts ticks since the last service and flags the expiring tick.
// Assumes tick is a one-cycle enable. The count stops after one expiry
// until the next accepted write.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int RES_STEP = 2,
    parameter int CNT_W    = MULT_W + ((1 << RES_W) - 1) * RES_STEP
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  wd_cfg_t cfg,
    input  logic    wr_ok,
    input  logic    pwr_fail,
    output logic    expire
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             done;
    logic             armed;

    // Timeout length in ticks: multiplier scaled by 2^(code*RES_STEP)
    assign limit = CNT_W'(cfg.mult) << (int'(cfg.res) * RES_STEP);
    assign armed = (cfg.mult != '0) && !done;

    // Expiry on the tick that completes the period, unless serviced now
    assign expire = armed && tick && !wr_ok && !pwr_fail && (cnt == limit - CNT_W'(1));

    // Tick counter with one-shot stop after expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (wr_ok || pwr_fail) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (expire) begin
            cnt  <= '0;
            done <= 1'b1;
        end else if (armed && tick) begin
            cnt  <= cnt + CNT_W'(1);
        end
    end

    p_write_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (cnt == '0));
    p_count_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mult != '0) |-> (cnt < limit));
endmodule

// File: rtl/wdog_steer.sv
// Turns an expiry into either a fixed reset pulse or a held interrupt,
// and emits the one-cycle timeout flag.
// Assumes expire lasts a single cycle.
module wdog_steer #(
    parameter int RST_CYCLES = 6,
    parameter int PC_W       = $clog2(RST_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic steer,
    input  logic wr_ok,
    input  logic pwr_fail,
    output logic pulse_active,
    output logic rst_out_n,
    output logic int_out_n,
    output logic flag
);
    logic [PC_W-1:0] pcnt;
    logic            int_q;

    // Reset pulse length counter
    always_ff @(posedge clk) begin
        if (!rst_n)                pcnt <= '0;
        else if (expire && steer)  pcnt <= PC_W'(RST_CYCLES);
        else if (pcnt != '0)       pcnt <= pcnt - PC_W'(1);
    end

    // Interrupt level: set on an interrupt-steered expiry, released by service
    always_ff @(posedge clk) begin
        if (!rst_n)                int_q <= 1'b0;
        else if (pwr_fail || wr_ok) int_q <= 1'b0;
        else if (expire && !steer) int_q <= 1'b1;
    end

    // Flag pulse, one cycle per expiry
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= expire;
    end

    assign pulse_active = (pcnt != '0);
    assign rst_out_n    = !pulse_active;
    assign int_out_n    = !int_q;

    p_int_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_out_n && !wr_ok && !pwr_fail) |=> !int_out_n);
    p_flag_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> !flag);
endmodule

// File: rtl/wdog_supervisor.sv
// Top of the steerable watchdog: configuration byte, tick timer and
// output steering.
// Assumes all inputs are synchronous to clk.
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int RES_STEP   = 2,
    parameter int RST_CYCLES = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             pwr_fail,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             wd_rst_n,
    output logic             wd_int_n,
    output logic             wd_flag
);
    localparam int CNT_W = MULT_W + ((1 << RES_W) - 1) * RES_STEP;

    wd_cfg_t cfg_q;
    logic    wr_ok;
    logic    expire;
    logic    pulse_active;

    wdog_cfg_reg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cfg_wr),
        .wr_data      (wd_cfg_t'(cfg_wdata)),
        .pwr_fail     (pwr_fail),
        .pulse_active (pulse_active),
        .clr_req      (expire && cfg_q.steer),
        .cfg_q        (cfg_q),
        .wr_ok        (wr_ok)
    );

    wdog_timer #(.RES_STEP(RES_STEP), .CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cfg      (cfg_q),
        .wr_ok    (wr_ok),
        .pwr_fail (pwr_fail),
        .expire   (expire)
    );

    wdog_steer #(.RST_CYCLES(RST_CYCLES)) u_str (
        .clk          (clk),
        .rst_n        (rst_n),
        .expire       (expire),
        .steer        (cfg_q.steer),
        .wr_ok        (wr_ok),
        .pwr_fail     (pwr_fail),
        .pulse_active (pulse_active),
        .rst_out_n    (wd_rst_n),
        .int_out_n    (wd_int_n),
        .flag         (wd_flag)
    );

    assign cfg_rdata = cfg_q;

    p_pulse_cfg_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_rst_n |-> (cfg_rdata == '0));
    p_flag_needs_mult_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wd_flag |-> ($past(cfg_rdata[CFG_W-2:RES_W]) != '0));
    p_service_blocks_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !pulse_active && !pwr_fail) |=> !wd_flag);
endmodule

// File: tb/sim_wdog_supervisor.sv
module sim_wdog_supervisor;
    localparam int RST_CYCLES = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       pwr_fail = 1'b0;
    logic [7:0] cfg_rdata;
    logic       wd_rst_n, wd_int_n, wd_flag;

    int total = 0;
    int fails = 0;
    bit exp_q[$];

    always #5 clk = ~clk;

    wdog_supervisor #(.RES_STEP(2), .RST_CYCLES(RST_CYCLES)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .pwr_fail(pwr_fail), .cfg_rdata(cfg_rdata),
        .wd_rst_n(wd_rst_n), .wd_int_n(wd_int_n), .wd_flag(wd_flag)
    );

    function automatic logic [7:0] enc(input bit s, input int m, input int r);
        return {s, 5'(m), 2'(r)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic pwr_pulse();
        @(negedge clk); pwr_fail = 1'b1;
        @(negedge clk); pwr_fail = 1'b0;
    endtask

    // Monitor: every flag pulse must match the next queued expectation (R5)
    always @(negedge clk) begin
        if (rst_n && wd_flag) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected timeout", 1, 0);
            end else begin
                bit s;
                s = exp_q.pop_front();
                if (s) check("R6 reset low at timeout", wd_rst_n, 0);
                else   check("R7 int low at timeout", wd_int_n, 0);
            end
        end
    end

    initial begin
        #1_000_000;
        check("watchdog expired", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cfg", cfg_rdata, 0);
        check("R1 rst", wd_rst_n, 1);
        check("R1 int", wd_int_n, 1);
        check("R1 flag", wd_flag, 0);

        // R2/R7 interrupt steering, M=3 C=0 -> 3 ticks
        wr(enc(0, 3, 0));
        check("R2 cfg readback", cfg_rdata, 8'h0C);
        ticks(2);
        check("R2 not early", wd_int_n, 1);
        exp_q.push_back(1'b0);
        ticks(1);
        check("R7 int low", wd_int_n, 0);
        ticks(5);
        check("R7 int held", wd_int_n, 0);
        wr(enc(0, 3, 0));
        check("R7 int released by write", wd_int_n, 1);

        // R3 multiplier zero
        wr(enc(0, 0, 3));
        ticks(100);
        check("R3 disabled", wd_int_n, 1);

        // R2 resolution codes
        wr(enc(0, 2, 1)); ticks(7);
        check("R2 code1 not early", wd_int_n, 1);
        exp_q.push_back(1'b0); ticks(1);
        check("R2 code1 at 8", wd_int_n, 0);
        wr(enc(0, 1, 2)); ticks(15);
        check("R2 code2 not early", wd_int_n, 1);
        exp_q.push_back(1'b0); ticks(1);
        check("R2 code2 at 16", wd_int_n, 0);
        wr(enc(0, 1, 3)); ticks(63);
        check("R2 code3 not early", wd_int_n, 1);
        exp_q.push_back(1'b0); ticks(1);
        check("R2 code3 at 64", wd_int_n, 0);

        // R4 restart by write
        wr(enc(0, 2, 0)); ticks(1);
        wr(enc(0, 2, 0)); ticks(1);
        check("R4 restarted", wd_int_n, 1);
        exp_q.push_back(1'b0); ticks(1);
        check("R4 after restart", wd_int_n, 0);

        // R4 write in the expiry cycle is a service
        wr(enc(0, 1, 0));
        @(negedge clk); tick = 1'b1; cfg_wr = 1'b1; cfg_wdata = enc(0, 1, 0);
        @(negedge clk); tick = 1'b0; cfg_wr = 1'b0;
        check("R4 same-cycle service", wd_int_n, 1);
        exp_q.push_back(1'b0); ticks(1);
        check("R4 later expiry", wd_int_n, 0);

        // R6 reset steering, pulse length, cfg cleared, write ignored
        wr(enc(1, 1, 0));
        exp_q.push_back(1'b1);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        begin
            int lows = 0;
            while (!wd_rst_n && lows < 50) begin
                lows++;
                check("R6 cfg cleared in pulse", cfg_rdata, 0);
                cfg_wr = (lows == 2);
                cfg_wdata = enc(0, 5, 1);
                @(negedge clk);
            end
            cfg_wr = 1'b0;
            check("R6 pulse length", lows, RST_CYCLES);
        end
        check("R6 write ignored", cfg_rdata, 0);
        check("R6 int untouched", wd_int_n, 1);

        // R8 power fail releases interrupt and disarms
        wr(enc(0, 1, 0));
        exp_q.push_back(1'b0); ticks(1);
        check("R8 int low before", wd_int_n, 0);
        pwr_pulse();
        check("R8 int released", wd_int_n, 1);
        check("R8 cfg cleared", cfg_rdata, 0);
        wr(enc(0, 2, 0));
        pwr_pulse();
        ticks(10);
        check("R8 disarmed", wd_int_n, 1);
        check("R8 cfg stays clear", cfg_rdata, 0);

        repeat (4) @(negedge clk);
        check("R5 all expected timeouts seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule